// File: doc/BRIEF.md
# Time-Multiplexed Interrupt Level Encoder

This block is the interrupt front end of a multichannel timer. Every channel owns a status flag and an enable bit. The channel's own function logic raises the flag with a one-cycle pulse, and software clears it. When at least one flag is set and its enable bit is also set, the block requests service at a single level that software programs, from 1 to 31. The hardware assigns no priority among channels: any mix of pending channels produces the same request.

The 32 request levels share an 8-line, active-low request bus. A free-running slot counter steps through four time slots, and each slot carries eight levels. Software picks the slot in which this module may drive. The module pulls one line low only while the counter is in that slot and the upper bits of the level name the same slot. The line it pulls is given by the low three bits of the level. A small register port gives software access to the enable mask, the status flags and the configuration word.

Top module: `irq_slot_encoder`

## Requirements
- R1: After reset the enable mask, the status flags and the configuration word all read as zero, every `irq_n` line is high and `slot_phase` is 0.
- R2: A 1 on bit i of `ch_set` at a clock edge sets status flag i. The flag stays set until software clears it.
- R3: A register write to address 1 (status) clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R4: When a channel's set pulse and a clear of that same flag arrive in the same cycle, the flag ends up set.
- R5: `pending` is high exactly when some flag is set and its enable bit is also set. When `pending` is low, all `irq_n` lines are high.
- R6: `slot_phase` is 0 in the first cycle after reset is released. It then advances by one at every clock edge and wraps from 3 to 0.
- R7: With `pending` high, level L (bits 4:0 of the configuration word) and slot select S (bits 9:8 of the configuration word), line L[2:0] of `irq_n` is low only in a cycle where `slot_phase` equals S and L[4:3] equals S. In every other case all lines are high, so at most one line is ever low.
- R8: A level of 0 suppresses every request, whatever the flags and the enable mask hold.
- R9: Register map: address 0 is the enable mask (the low N_CH bits, read/write), address 1 is the status flags, address 2 is the configuration word (level at bits 4:0, slot select at bits 9:8), and address 3 reads as zero. Bits outside these fields read as zero.
- R10: A request depends only on whether some enabled flag is pending, not on which flags or how many. One pending channel and many pending channels drive the same bus pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_set | input | N_CH | Per-channel flag set pulses from the function logic |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DATA_W | Register read data (combinational) |
| irq_n | output | 8 | Time-shared request bus, active low |
| pending | output | 1 | Some enabled flag is set |
| slot_phase | output | 2 | Current time slot |

## Verification
The hardest case to reach from the ports is the single cycle in which the slot counter, the slot select field and the upper level bits all agree. Missing any one of the three keeps the bus silent, and so does a level of zero. The bench therefore keeps one enabled flag pending and walks all 32 levels against all four slot selects. For each pair it samples four consecutive cycles, so every counter phase meets every configuration. A set pulse that lands in the same cycle as a write-one clear needs exact cycle alignment, so the bench drives both on the same clock edge.

// File: rtl/irq_slot_pkg.sv
package irq_slot_pkg;
  localparam int LVL_W   = 5;
  localparam int SLOT_W  = 2;
  localparam int LINE_W  = LVL_W - SLOT_W;
  localparam int BUS_W   = 1 << LINE_W;
  localparam int ADDR_W  = 2;
  localparam int CFG_LVL_LSB = 0;
  localparam int CFG_SEL_LSB = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_ENABLE = 2'd0,
    REG_STATUS = 2'd1,
    REG_CONFIG = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;

  // slot that a given level belongs to
  function automatic logic [SLOT_W-1:0] level_group(input logic [LVL_W-1:0] lvl);
    return lvl[LVL_W-1 -: SLOT_W];
  endfunction

  // line index inside the slot
  function automatic logic [LINE_W-1:0] level_line(input logic [LVL_W-1:0] lvl);
    return lvl[LINE_W-1:0];
  endfunction

  // active-low one-cold pattern for a line
  function automatic logic [BUS_W-1:0] line_pattern_n(input logic [LINE_W-1:0] line);
    return ~(BUS_W'(1) << line);
  endfunction

  // true when the module owns the bus this cycle
  function automatic logic slot_owned(input logic [LVL_W-1:0] lvl,
                                      input logic [SLOT_W-1:0] sel,
                                      input logic [SLOT_W-1:0] slot);
    return (lvl != '0) && (level_group(lvl) == sel) && (slot == sel);
  endfunction
endpackage

// File: rtl/irq_slot_regs.sv
module irq_slot_regs
  import irq_slot_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CH-1:0]          ch_set,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  output logic [N_CH-1:0]          enable_q,
  output logic [N_CH-1:0]          status_q,
  output logic [LVL_W-1:0]         level_q,
  output logic [SLOT_W-1:0]        sel_q
);
  logic            wr_enable, wr_status, wr_config;
  logic [N_CH-1:0] clr_mask;
  logic [N_CH-1:0] status_d;

  assign wr_enable = wr_en && (reg_sel_e'(wr_addr) == REG_ENABLE);
  assign wr_status = wr_en && (reg_sel_e'(wr_addr) == REG_STATUS);
  assign wr_config = wr_en && (reg_sel_e'(wr_addr) == REG_CONFIG);
  assign clr_mask  = wr_status ? wr_data[N_CH-1:0] : '0;

  // per-channel flag update: set pulse beats the clear
  for (genvar i = 0; i < N_CH; i++) begin : g_flag
    always_comb begin
      if (ch_set[i])       status_d[i] = 1'b1;
      else if (clr_mask[i]) status_d[i] = 1'b0;
      else                 status_d[i] = status_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      status_q <= '0;
      level_q  <= '0;
      sel_q    <= '0;
    end else begin
      status_q <= status_d;
      if (wr_enable) enable_q <= wr_data[N_CH-1:0];
      if (wr_config) begin
        level_q <= wr_data[CFG_LVL_LSB +: LVL_W];
        sel_q   <= wr_data[CFG_SEL_LSB +: SLOT_W];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (reg_sel_e'(rd_addr))
      REG_ENABLE: rd_data[N_CH-1:0] = enable_q;
      REG_STATUS: rd_data[N_CH-1:0] = status_q;
      REG_CONFIG: begin
        rd_data[CFG_LVL_LSB +: LVL_W]  = level_q;
        rd_data[CFG_SEL_LSB +: SLOT_W] = sel_q;
      end
      REG_SPARE:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_slot_counter.sv
module irq_slot_counter
  import irq_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_q + 1'b1;
  end
endmodule

// File: rtl/irq_slot_driver.sv
module irq_slot_driver
  import irq_slot_pkg::*;
#(
  parameter int N_CH = 16
) (
  input  logic [N_CH-1:0]   status,
  input  logic [N_CH-1:0]   enable,
  input  logic [LVL_W-1:0]  level,
  input  logic [SLOT_W-1:0] sel,
  input  logic [SLOT_W-1:0] slot,
  output logic              pending,
  output logic              drive_hit,
  output logic [BUS_W-1:0]  irq_n
);
  logic [N_CH-1:0] ch_req;

  for (genvar i = 0; i < N_CH; i++) begin : g_req
    assign ch_req[i] = status[i] & enable[i];
  end

  assign pending   = |ch_req;
  assign drive_hit = pending && slot_owned(level, sel, slot);
  assign irq_n     = drive_hit ? line_pattern_n(level_line(level)) : '1;
endmodule

// File: rtl/irq_slot_encoder.sv
module irq_slot_encoder
  import irq_slot_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   ch_set,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [7:0]        irq_n,
  output logic              pending,
  output logic [1:0]        slot_phase
);
  logic [N_CH-1:0]   enable_q;
  logic [N_CH-1:0]   status_q;
  logic [LVL_W-1:0]  level_q;
  logic [SLOT_W-1:0] sel_q;
  logic [SLOT_W-1:0] slot_q;
  logic              drive_hit;

  irq_slot_regs #(.N_CH(N_CH), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ch_set(ch_set),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .enable_q(enable_q), .status_q(status_q),
    .level_q(level_q), .sel_q(sel_q)
  );

  irq_slot_counter u_ctr (.clk(clk), .rst_n(rst_n), .slot_q(slot_q));

  irq_slot_driver #(.N_CH(N_CH)) u_drv (
    .status(status_q), .enable(enable_q), .level(level_q),
    .sel(sel_q), .slot(slot_q),
    .pending(pending), .drive_hit(drive_hit), .irq_n(irq_n)
  );

  assign slot_phase = slot_q;
endmodule

// File: rtl/irq_slot_encoder_chk.sv
module irq_slot_encoder_chk
  import irq_slot_pkg::*;
#(
  parameter int N_CH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_CH-1:0]   ch_set,
  input logic [N_CH-1:0]   status,
  input logic [N_CH-1:0]   enable,
  input logic [LVL_W-1:0]  level,
  input logic [SLOT_W-1:0] sel,
  input logic [SLOT_W-1:0] slot,
  input logic [BUS_W-1:0]  irq_n
);
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> slot == SLOT_W'($past(slot) + 1'b1)); // R6
  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~irq_n) <= 1); // R7
  AST_SLOT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n != '1) |-> (slot == sel && level[LVL_W-1 -: SLOT_W] == sel)); // R7
  AST_LEVEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> (irq_n == '1)); // R8
  AST_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n != '1) |-> ((status & enable) != '0)); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_set != '0) |=> ((status & $past(ch_set)) == $past(ch_set))); // R4
endmodule

bind irq_slot_encoder irq_slot_encoder_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_set(ch_set), .status(status_q),
  .enable(enable_q), .level(level_q), .sel(sel_q), .slot(slot_q),
  .irq_n(irq_n)
);

// File: tb/irq_slot_encoder_tb.sv
module irq_slot_encoder_tb;
  localparam int N_CH = 16;
  localparam int DW   = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N_CH-1:0] ch_set = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [7:0]    irq_n;
  logic          pending;
  logic [1:0]    slot_phase;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [1:0] bslot;

  always #5 clk = ~clk;

  irq_slot_encoder #(.N_CH(N_CH), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ch_set(ch_set), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_n(irq_n), .pending(pending),
    .slot_phase(slot_phase)
  );

  // bench's own slot model
  always @(posedge clk or negedge rst_n)
    if (!rst_n) bslot <= 2'd0; else bslot <= bslot + 2'd1;

  function automatic logic [7:0] exp_bus(input int lvl, input int sel, input int slot, input bit pend);
    if (!pend || lvl == 0) return 8'hFF;
    if ((lvl / 8) != sel || slot != sel) return 8'hFF;
    return 8'hFF ^ (8'h01 << (lvl % 8));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [N_CH-1:0] s);
    @(negedge clk); ch_set = s;
    @(negedge clk); ch_set = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_up();
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic [7:0] ref_pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, sampled before the first active edge
    rd(2'd0, d); check("R1 enable", d, 0);
    rd(2'd1, d); check("R1 status", d, 0);
    rd(2'd2, d); check("R1 config", d, 0);
    check("R1 irq_n", irq_n, 8'hFF);
    check("R1 slot", slot_phase, 0);
    // R6 slot sequence
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); check("R6 slot", slot_phase, bslot);
      check("R6 slot arith", slot_phase, (k + 1) % 4);
    end
    // R9 register map
    wr(2'd0, 32'hFFFF_A5C3); rd(2'd0, d); check("R9 enable rb", d, 32'h0000_A5C3);
    wr(2'd2, 32'hFFFF_FF1A); rd(2'd2, d); check("R9 config rb", d, 32'h0000_031A);
    rd(2'd3, d); check("R9 spare", d, 0);
    wr(2'd0, 0); wr(2'd2, 0);
    // R2 set
    pulse(16'h0104); rd(2'd1, d); check("R2 set", d, 32'h0104);
    repeat (3) @(negedge clk); rd(2'd1, d); check("R2 hold", d, 32'h0104);
    // R3 write-one clear, write-zero ignored
    wr(2'd1, 0); rd(2'd1, d); check("R3 w0", d, 32'h0104);
    wr(2'd1, 32'h0004); rd(2'd1, d); check("R3 w1c", d, 32'h0100);
    // R4 set beats clear in the same cycle
    @(negedge clk); ch_set = 16'h0008; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h0108;
    @(negedge clk); ch_set = '0; wr_en = 1'b0;
    rd(2'd1, d); check("R4 set wins", d, 32'h0008);
    // R5 disabled flags never request; level 13 in slot 1
    wr(2'd2, 32'h0000_010D);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R5 no pend", pending, 0);
      check("R5 bus idle", irq_n, 8'hFF);
    end
    wr(2'd0, 32'h0001); @(negedge clk); check("R5 other bit", pending, 0);
    wr(2'd0, 32'h0008); @(negedge clk); check("R5 pend", pending, 1);
    // R10 one vs many pending channels
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); check("R10 single", irq_n, exp_bus(13, 1, bslot, 1'b1));
    end
    pulse(16'hF0F0); wr(2'd0, 32'hFFFF);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ref_pat = exp_bus(13, 1, bslot, 1'b1);
      check("R10 many", irq_n, ref_pat);
    end
    // R7/R8 sweep: every level against every slot select, four phases each
    wr(2'd1, 32'hFFFF); wr(2'd0, 32'h0001); pulse(16'h0001);
    for (int lv = 0; lv < 32; lv++) begin
      for (int s = 0; s < 4; s++) begin
        wr(2'd2, (s << 8) | lv);
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          check(lv == 0 ? "R8 level zero" : "R7 slot drive", irq_n, exp_bus(lv, s, bslot, 1'b1));
        end
      end
    end
    // R5 clearing the last flag drops the request
    wr(2'd2, 32'h0000_0305);
    wr(2'd1, 32'h0001);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); check("R5 cleared", irq_n, 8'hFF);
    end
    check("R5 pend low", pending, 0);
    done = 1'b1;
    finish_up();
  end
endmodule